// File: doc/BRIEF.md
# Dual-Rail AMI Receive Decoder

This block sits behind a line receiver that delivers an alternate-mark-inversion signal as two rails: one for positive pulses and one for negative pulses. On every receive clock it samples both rails. It produces a single unipolar data bit, which is the OR of the two rails. It also produces a one-cycle flag whenever the line breaks the alternation rule. Downstream logic, such as a zero-substitution decoder or an error counter, takes both outputs one clock after the sample.

To detect a bipolar violation, the block remembers the polarity of the most recent valid mark. A mark with the same polarity as that remembered one is flagged. Sometimes no remembered polarity exists yet: after a full reset, after a synchronous datapath reset, or during and after a loss-of-signal indication. In those cases the first valid mark only sets the reference and raises no flag. A sample with both rails high cannot be a legal symbol, so it is always flagged and it leaves the reference untouched. Zeros carry no polarity and are transparent to the tracking.

Top module: `ami_rx_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `data_out` and `bpv_out` are 0.
- R2: Outside reset and datapath reset, `data_out` equals `rx_pos | rx_neg` as sampled on the previous clock edge.
- R3: After `rst`, the first valid mark (exactly one rail high) raises no violation.
- R4: A sample with `dp_rst` high forces both outputs to 0 on the next cycle and clears the reference, so the next valid mark raises no violation.
- R5: After `los` falls, the first valid mark raises no violation.
- R6: A valid mark whose polarity matches the previous valid mark raises `bpv_out` for exactly the one cycle that follows that sample.
- R7: A valid mark of opposite polarity to the previous valid mark raises no violation.
- R8: A sample with both rails high (outside `rst`, `dp_rst` and `los`) raises `bpv_out` on the next cycle and does not change the stored polarity.
- R9: A zero sample (both rails low) raises no violation and does not change the stored polarity.
- R10: While `los` is high, no violation is reported and the reference polarity is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_rst | input | 1 | Synchronous datapath reset; clears outputs and reference polarity |
| los | input | 1 | Loss-of-signal indication from an external detector |
| rx_pos | input | 1 | Positive-pulse rail |
| rx_neg | input | 1 | Negative-pulse rail |
| data_out | output | 1 | Registered unipolar data bit |
| bpv_out | output | 1 | Registered one-cycle bipolar-violation pulse |

## Verification
The bench runs every four-symbol sequence over zero, plus, minus and both-rails after a datapath reset. It then runs every five-symbol sequence that also mixes in loss-of-signal samples. Each output is compared against a small arithmetic model. A design that forgot to clear the reference would flag the first mark after a datapath reset or a loss of signal, and one that let zeros reset the reference would miss plus-zero-plus violations. A design that updated the polarity on a both-rails sample would misjudge the mark that follows it. A violation stretched over two cycles, or one shifted by a cycle, shows up as a mismatch on the neighbouring sample.

// File: rtl/ami_rx_pkg.sv
package ami_rx_pkg;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_PLUS  = 2'd1,
        SYM_MINUS = 2'd2,
        SYM_CLASH = 2'd3
    } line_sym_e;

    typedef struct packed {
        logic known;
        logic minus;
    } mark_ref_t;

    typedef struct packed {
        logic bit_val;
        logic viol;
    } rx_word_t;

    localparam mark_ref_t REF_NONE = '{known: 1'b0, minus: 1'b0};
    localparam rx_word_t  WORD_IDLE = '{bit_val: 1'b0, viol: 1'b0};

    function automatic line_sym_e classify(input logic pos, input logic neg);
        case ({pos, neg})
            2'b10:   return SYM_PLUS;
            2'b01:   return SYM_MINUS;
            2'b11:   return SYM_CLASH;
            default: return SYM_SPACE;
        endcase
    endfunction

    function automatic logic is_mark(input line_sym_e s);
        return (s == SYM_PLUS) || (s == SYM_MINUS);
    endfunction

    function automatic logic repeats(input mark_ref_t r, input line_sym_e s);
        return r.known && is_mark(s) && (r.minus == (s == SYM_MINUS));
    endfunction

endpackage

// File: rtl/ami_sym_classify.sv
module ami_sym_classify
    import ami_rx_pkg::*;
(
    input  logic      pos_i,
    input  logic      neg_i,
    output line_sym_e sym_o,
    output logic      unipolar_o
);
    always_comb begin
        sym_o      = classify(pos_i, neg_i);
        unipolar_o = pos_i | neg_i;
    end
endmodule

// File: rtl/ami_mark_ref.sv
module ami_mark_ref
    import ami_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear_i,
    input  line_sym_e sym_i,
    output logic      viol_o
);
    mark_ref_t ref_q;
    mark_ref_t ref_d;

    always_comb begin
        ref_d  = ref_q;
        viol_o = 1'b0;
        if (clear_i) begin
            ref_d = REF_NONE;
        end else begin
            unique case (sym_i)
                SYM_PLUS, SYM_MINUS: begin
                    viol_o      = repeats(ref_q, sym_i);
                    ref_d.known = 1'b1;
                    ref_d.minus = (sym_i == SYM_MINUS);
                end
                SYM_CLASH: viol_o = 1'b1;
                default:   viol_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ref_q <= REF_NONE;
        else     ref_q <= ref_d;
    end
endmodule

// File: rtl/ami_rx_outreg.sv
module ami_rx_outreg
    import ami_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush_i,
    input  logic mute_i,
    input  logic bit_i,
    input  logic viol_i,
    output logic bit_o,
    output logic viol_o
);
    rx_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            word_q <= WORD_IDLE;
        end else begin
            word_q.bit_val <= bit_i;
            word_q.viol    <= viol_i && !mute_i;
        end
    end

    assign bit_o  = word_q.bit_val;
    assign viol_o = word_q.viol;
endmodule

// File: rtl/ami_rx_decoder.sv
module ami_rx_decoder
    import ami_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dp_rst,
    input  logic los,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic data_out,
    output logic bpv_out
);
    line_sym_e sym;
    logic      unipolar;
    logic      viol_raw;
    logic      ref_clear;

    assign ref_clear = dp_rst | los;

    ami_sym_classify u_classify (
        .pos_i      (rx_pos),
        .neg_i      (rx_neg),
        .sym_o      (sym),
        .unipolar_o (unipolar)
    );

    ami_mark_ref u_mark_ref (
        .clk     (clk),
        .rst     (rst),
        .clear_i (ref_clear),
        .sym_i   (sym),
        .viol_o  (viol_raw)
    );

    ami_rx_outreg u_outreg (
        .clk     (clk),
        .rst     (rst),
        .flush_i (dp_rst),
        .mute_i  (los),
        .bit_i   (unipolar),
        .viol_i  (viol_raw),
        .bit_o   (data_out),
        .viol_o  (bpv_out)
    );
endmodule

// File: rtl/ami_rx_decoder_chk.sv
module ami_rx_decoder_chk (
    input logic clk,
    input logic rst,
    input logic dp_rst,
    input logic los,
    input logic rx_pos,
    input logic rx_neg,
    input logic data_out,
    input logic bpv_out
);
    p_clear_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!data_out && !bpv_out));

    p_unipolar_or_r2: assert property (@(posedge clk) disable iff (rst)
        !dp_rst |=> (data_out == $past(rx_pos | rx_neg)));

    p_dprst_flush_r4: assert property (@(posedge clk) disable iff (rst)
        dp_rst |=> (!data_out && !bpv_out));

    p_clash_flagged_r8: assert property (@(posedge clk) disable iff (rst)
        (!dp_rst && !los && rx_pos && rx_neg) |=> bpv_out);

    p_space_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!rx_pos && !rx_neg) |=> !bpv_out);

    p_los_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        los |=> !bpv_out);

    p_first_after_los_r5: assert property (@(posedge clk) disable iff (rst)
        (los && !dp_rst) |=> (!bpv_out || !$past(rx_pos ^ rx_neg)));
endmodule

bind ami_rx_decoder ami_rx_decoder_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .dp_rst   (dp_rst),
    .los      (los),
    .rx_pos   (rx_pos),
    .rx_neg   (rx_neg),
    .data_out (data_out),
    .bpv_out  (bpv_out)
);

// File: tb/test_ami_rx_decoder.sv
module test_ami_rx_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp_rst = 1'b0;
    logic los = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic data_out;
    logic bpv_out;

    int total = 0;
    int bad = 0;
    int mv = 0;       // 0 none, 1 plus, 2 minus
    int reason = 3;   // what cleared the reference last: 3 rst, 4 dp_rst, 5 los
    bit done = 0;

    always #2 clk = ~clk;

    ami_rx_decoder i_ami_rx_decoder (
        .clk (clk), .rst (rst), .dp_rst (dp_rst), .los (los),
        .rx_pos (rx_pos), .rx_neg (rx_neg),
        .data_out (data_out), .bpv_out (bpv_out)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic step(input logic p, input logic n, input logic l, input logic d);
        logic  exp_d, exp_b;
        string btag, dtag;
        int    cur;
        @(negedge clk);
        rx_pos = p; rx_neg = n; los = l; dp_rst = d;
        dtag = "R2";
        if (d) begin
            exp_d = 0; exp_b = 0; mv = 0; reason = 4; btag = "R4"; dtag = "R4";
        end else if (l) begin
            exp_d = p | n; exp_b = 0; mv = 0; reason = 5; btag = "R10";
        end else begin
            exp_d = p | n;
            if (p && n) begin
                exp_b = 1; btag = "R8";
            end else if (!p && !n) begin
                exp_b = 0; btag = "R9";
            end else begin
                cur = p ? 1 : 2;
                if (mv == 0) begin
                    exp_b = 0;
                    btag = (reason == 3) ? "R3" : (reason == 4) ? "R4" : "R5";
                end else begin
                    exp_b = (mv == cur);
                    btag = exp_b ? "R6" : "R7";
                end
                mv = cur;
            end
        end
        @(posedge clk);
        #1;
        check(btag, "bpv_out", bpv_out, exp_b);
        check(dtag, "data_out", data_out, exp_d);
    endtask

    task automatic sym_step(input int s);
        case (s)
            0: step(0, 0, 0, 0);
            1: step(1, 0, 0, 0);
            2: step(0, 1, 0, 0);
            3: step(1, 1, 0, 0);
            default: step(1, 0, 1, 0);
        endcase
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs held low under reset and just after
        repeat (3) @(posedge clk);
        #1;
        check("R1", "data_out in reset", data_out, 1'b0);
        check("R1", "bpv_out in reset", bpv_out, 1'b0);
        @(negedge clk);
        rx_pos = 1; rx_neg = 1;
        @(posedge clk); #1;
        check("R1", "data_out in reset", data_out, 1'b0);
        check("R1", "bpv_out in reset", bpv_out, 1'b0);
        @(negedge clk);
        rst = 0; rx_pos = 0; rx_neg = 0;
        mv = 0; reason = 3;
        @(posedge clk); #1;
        check("R1", "data_out after reset", data_out, 1'b0);
        check("R1", "bpv_out after reset", bpv_out, 1'b0);

        // R3: first mark after reset is quiet, repeat is flagged (R6)
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        step(0, 1, 0, 0);

        // every four-symbol sequence over space, plus, minus, clash
        for (int seq = 0; seq < 256; seq++) begin
            step(0, 0, 0, 1);
            for (int k = 0; k < 4; k++) sym_step((seq >> (2 * k)) & 3);
        end

        // every five-symbol sequence including loss-of-signal samples
        for (int seq = 0; seq < 3125; seq++) begin
            int v = seq;
            step(0, 0, 0, 1);
            for (int k = 0; k < 5; k++) begin
                sym_step(v % 5);
                v = v / 5;
            end
        end
        finish_run();
    end
endmodule